// File: doc/BRIEF.md
# External Interrupt Priority Controller

This block gathers the external interrupt sources of a processor core and presents at most one of them at a time. There are three kinds of source. A time-of-day comparator event and a CPU-timer event each set a pending flag of their own. Queued requests sit on a small last-in, first-out stack, and each one carries a 16-bit interruption code, a 32-bit parameter and a 64-bit parameter. Every source also raises a hard-interrupt request line to the core.

When the PSW external mask is set and no other exception has been selected, a non-empty stack presents its top entry to the PSW-swap logic through a valid/ack pair. An empty stack causes the highest pending timer to be turned into a stack entry with a fixed code, and that entry is presented one cycle later. The swap logic takes the code, the two parameters and a CPU-address field. Each ack pops one entry and updates the flags. The hard-interrupt request falls only once nothing is pending.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, irq_valid_o, hard_req_o, all three pending outputs, ovf_o and fatal_o are 0.
- R2: A tod_evt_i or cpt_evt_i pulse sets pend_tod_o or pend_cpt_o respectively, and sets hard_req_o, from the next cycle on.
- R3: While ext_mask_i is 0 or exc_busy_i is 1, irq_valid_o stays 0, no timer is converted and the pending flags hold.
- R4: A non-empty stack is always served before any timer. When the stack is empty, a pending time-of-day event is converted before a pending CPU-timer event.
- R5: A conversion clears its own timer flag and pushes an entry with code 0x1004 (time-of-day) or 0x1005 (CPU-timer) and both parameters zero. That entry is presented in the cycle after the conversion edge.
- R6: Entries are delivered in last-in, first-out order. irq_code_o, irq_p32_o and irq_p64_o show the top entry.
- R7: pend_ext_o is 1 exactly when the stack holds at least one entry. It falls when the last entry is popped.
- R8: cpu_addr_o equals cpu_num_i bitwise ORed with 0x0D00.
- R9: On an ack, hard_req_o is cleared only if no pending flag remains set after that cycle. Otherwise it stays 1.
- R10: A push_i while the stack holds DEPTH entries and no pop happens in that cycle is dropped, leaving the contents unchanged. It also sets ovf_o, which stays set until reset.
- R11: ack_i with ext_mask_i at 0 or with an empty stack sets fatal_o, which stays set until reset. Such an ack pops nothing.
- R12: An ack_i while irq_valid_o is 1 pops the top entry, so the entry below it is presented from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tod_evt_i | input | 1 | Time-of-day comparator event pulse |
| cpt_evt_i | input | 1 | CPU-timer event pulse |
| push_i | input | 1 | Push a queued external request |
| push_code_i | input | 16 | Interruption code of pushed request |
| push_p32_i | input | 32 | 32-bit parameter of pushed request |
| push_p64_i | input | 64 | 64-bit parameter of pushed request |
| ext_mask_i | input | 1 | PSW external interrupt mask bit |
| exc_busy_i | input | 1 | Another exception is already selected |
| cpu_num_i | input | 16 | CPU number |
| ack_i | input | 1 | Delivery acknowledge from the PSW-swap logic |
| irq_valid_o | output | 1 | An interrupt is presented |
| irq_code_o | output | 16 | Presented interruption code |
| irq_p32_o | output | 32 | Presented 32-bit parameter |
| irq_p64_o | output | 64 | Presented 64-bit parameter |
| cpu_addr_o | output | 16 | CPU-address field |
| hard_req_o | output | 1 | Hard-interrupt request to the core |
| pend_ext_o | output | 1 | Queued external request pending |
| pend_tod_o | output | 1 | Time-of-day event pending |
| pend_cpt_o | output | 1 | CPU-timer event pending |
| ovf_o | output | 1 | Sticky stack overflow |
| fatal_o | output | 1 | Sticky fatal delivery error |

## Verification
The hardest situations to reach are the ones where sources overlap. One is a timer that is still waiting when the last queued entry is acked: the hard request must stay up and the conversion must follow one edge later. Another is a push arriving at a full stack in the same cycle as a pop. The directed part sets these up by masking delivery while loading events and entries, then opening the mask and acking step by step. A seeded random phase then mixes pushes and acks, including pop-plus-push on a full stack, and checks every cycle against a bench LIFO model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam logic [15:0] TOD_CODE    = 16'h1004;
  localparam logic [15:0] CPT_CODE    = 16'h1005;
  localparam logic [15:0] CPU_SUBCODE = 16'h0D00;

  typedef struct packed {
    logic [15:0] code;
    logic [31:0] p32;
    logic [63:0] p64;
  } ext_entry_t;
endpackage

// File: rtl/ext_irq_lifo.sv
module ext_irq_lifo
  import ext_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  ext_entry_t    wdata_i,
  input  logic          pop_i,
  output ext_entry_t    top_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          reject_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt;
  logic          do_pop, accept;
  logic [CW-1:0] wr_idx, top_idx;
  ext_entry_t    mem [DEPTH];

  assign do_pop   = pop_i && (cnt != '0);
  assign accept   = push_i && ((cnt != CW'(DEPTH)) || do_pop);
  assign reject_o = push_i && !accept;
  assign wr_idx   = do_pop ? cnt - CW'(1) : cnt;
  assign top_idx  = cnt - CW'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (accept && (wr_idx == CW'(i))) mem[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else begin
      case ({accept, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign top_o   = mem[top_idx[IW-1:0]];
  assign count_o = cnt;
  assign empty_o = (cnt == '0);
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb (
  input  logic ext_mask_i,
  input  logic exc_busy_i,
  input  logic q_empty_i,
  input  logic pend_tod_i,
  input  logic pend_cpt_i,
  input  logic push_i,
  output logic deliver_o,
  output logic conv_tod_o,
  output logic conv_cpt_o
);
  logic eligible, conv_ok;

  assign eligible   = ext_mask_i && !exc_busy_i;
  assign deliver_o  = eligible && !q_empty_i;
  // timers only enter an empty stack, and never collide with an external push
  assign conv_ok    = eligible && q_empty_i && !push_i;
  assign conv_tod_o = conv_ok && pend_tod_i;
  assign conv_cpt_o = conv_ok && !pend_tod_i && pend_cpt_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tod_evt_i,
  input  logic        cpt_evt_i,
  input  logic        push_i,
  input  logic [15:0] push_code_i,
  input  logic [31:0] push_p32_i,
  input  logic [63:0] push_p64_i,
  input  logic        ext_mask_i,
  input  logic        exc_busy_i,
  input  logic [15:0] cpu_num_i,
  input  logic        ack_i,
  output logic        irq_valid_o,
  output logic [15:0] irq_code_o,
  output logic [31:0] irq_p32_o,
  output logic [63:0] irq_p64_o,
  output logic [15:0] cpu_addr_o,
  output logic        hard_req_o,
  output logic        pend_ext_o,
  output logic        pend_tod_o,
  output logic        pend_cpt_o,
  output logic        ovf_o,
  output logic        fatal_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          deliver, conv_tod, conv_cpt, ack_ok, q_empty, reject;
  logic          lifo_push;
  logic [CW-1:0] q_count;
  ext_entry_t    wdata, top;
  logic          tod_q, cpt_q, hard_q, ovf_q, fatal_q;
  logic          tod_n, cpt_n, hard_n;

  ext_irq_arb u_arb (
    .ext_mask_i (ext_mask_i),
    .exc_busy_i (exc_busy_i),
    .q_empty_i  (q_empty),
    .pend_tod_i (tod_q),
    .pend_cpt_i (cpt_q),
    .push_i     (push_i),
    .deliver_o  (deliver),
    .conv_tod_o (conv_tod),
    .conv_cpt_o (conv_cpt)
  );

  assign ack_ok    = ack_i && deliver;
  assign lifo_push = push_i || conv_tod || conv_cpt;

  always_comb begin
    wdata = '0;
    if (push_i) begin
      wdata.code = push_code_i;
      wdata.p32  = push_p32_i;
      wdata.p64  = push_p64_i;
    end else if (conv_tod) wdata.code = TOD_CODE;
    else                   wdata.code = CPT_CODE;
  end

  ext_irq_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (lifo_push),
    .wdata_i  (wdata),
    .pop_i    (ack_ok),
    .top_o    (top),
    .count_o  (q_count),
    .empty_o  (q_empty),
    .reject_o (reject)
  );

  assign tod_n = tod_evt_i || (tod_q && !conv_tod);
  assign cpt_n = cpt_evt_i || (cpt_q && !conv_cpt);

  always_comb begin
    if (tod_evt_i || cpt_evt_i || push_i) hard_n = 1'b1;
    else if (ack_ok) hard_n = tod_n || cpt_n || (q_count > CW'(1));
    else hard_n = hard_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q   <= 1'b0;
      cpt_q   <= 1'b0;
      hard_q  <= 1'b0;
      ovf_q   <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      tod_q   <= tod_n;
      cpt_q   <= cpt_n;
      hard_q  <= hard_n;
      ovf_q   <= ovf_q || reject;
      fatal_q <= fatal_q || (ack_i && (!ext_mask_i || q_empty));
    end
  end

  assign irq_valid_o = deliver;
  assign irq_code_o  = top.code;
  assign irq_p32_o   = top.p32;
  assign irq_p64_o   = top.p64;
  assign cpu_addr_o  = cpu_num_i | CPU_SUBCODE;
  assign hard_req_o  = hard_q;
  assign pend_ext_o  = !q_empty;
  assign pend_tod_o  = tod_q;
  assign pend_cpt_o  = cpt_q;
  assign ovf_o       = ovf_q;
  assign fatal_o     = fatal_q;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tod_evt_i,
  input logic cpt_evt_i,
  input logic ext_mask_i,
  input logic exc_busy_i,
  input logic irq_valid_o,
  input logic hard_req_o,
  input logic pend_ext_o,
  input logic pend_tod_o,
  input logic pend_cpt_o,
  input logic ovf_o,
  input logic fatal_o
);
  a_r2_tod_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tod_evt_i |=> (pend_tod_o && hard_req_o));
  a_r2_cpt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpt_evt_i |=> (pend_cpt_o && hard_req_o));
  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_mask_i || exc_busy_i) |-> !irq_valid_o);
  a_r7_valid_needs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> pend_ext_o);
  a_r9_req_covers_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_ext_o || pend_tod_o || pend_cpt_o) |-> hard_req_o);
  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r11_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (.*);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        tod_evt_i, cpt_evt_i, push_i, ext_mask_i, exc_busy_i, ack_i;
  logic [15:0] push_code_i, cpu_num_i;
  logic [31:0] push_p32_i;
  logic [63:0] push_p64_i;
  logic        irq_valid_o, hard_req_o, pend_ext_o, pend_tod_o, pend_cpt_o, ovf_o, fatal_o;
  logic [15:0] irq_code_o, cpu_addr_o;
  logic [31:0] irq_p32_o;
  logic [63:0] irq_p64_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_code [DEPTH];
  logic [31:0] m_p32  [DEPTH];
  int          m_n;

  always #2.5 clk_i = ~clk_i;

  ext_irq_ctrl #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    {tod_evt_i, cpt_evt_i, push_i, ext_mask_i, exc_busy_i, ack_i} = '0;
    push_code_i = '0; push_p32_i = '0; push_p64_i = '0; cpu_num_i = '0;
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic push_one(input logic [15:0] c);
    push_i = 1'b1; push_code_i = c; push_p32_i = {16'hA5A5, c}; push_p64_i = {48'h0, c};
    tick();
    push_i = 1'b0;
  endtask

  task automatic ack_one();
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] n);
    return n | 16'h0D00;
  endfunction

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1", "valid", irq_valid_o, 0);
    chk("R1", "hard_req", hard_req_o, 0);
    chk("R1", "pending", {pend_ext_o, pend_tod_o, pend_cpt_o}, 0);
    chk("R1", "ovf/fatal", {ovf_o, fatal_o}, 0);

    // R2: events with mask clear
    tod_evt_i = 1; tick(); tod_evt_i = 0;
    chk("R2", "pend_tod", pend_tod_o, 1);
    chk("R2", "hard_req", hard_req_o, 1);
    cpt_evt_i = 1; tick(); cpt_evt_i = 0;
    chk("R2", "pend_cpt", pend_cpt_o, 1);

    // R3: busy blocks delivery and conversion
    ext_mask_i = 1; exc_busy_i = 1;
    tick(); tick();
    chk("R3", "valid busy", irq_valid_o, 0);
    chk("R3", "flags held", {pend_ext_o, pend_tod_o, pend_cpt_o}, 3'b011);

    // R4/R5: tod converted before cpt
    exc_busy_i = 0; cpu_num_i = 16'h0003;
    #1 chk("R5", "valid before conversion", irq_valid_o, 0);
    tick();
    chk("R4", "tod first", {pend_tod_o, pend_cpt_o}, 2'b01);
    chk("R5", "valid", irq_valid_o, 1);
    chk("R5", "tod code", irq_code_o, 16'h1004);
    chk("R5", "params zero", {irq_p32_o, irq_p64_o[31:0]}, 0);
    chk("R5", "p64 zero", irq_p64_o, 0);
    chk("R8", "cpu addr", cpu_addr_o, exp_addr(16'h0003));
    cpu_num_i = 16'h00F1;
    #1 chk("R8", "cpu addr 2", cpu_addr_o, 16'h0DF1);

    ack_one();
    chk("R7", "pend_ext cleared", pend_ext_o, 0);
    chk("R9", "hard stays with cpt", hard_req_o, 1);
    chk("R5", "no valid during conversion", irq_valid_o, 0);
    tick();
    chk("R5", "cpt code", irq_code_o, 16'h1005);
    chk("R5", "cpt valid", irq_valid_o, 1);
    ack_one();
    chk("R9", "hard dropped", hard_req_o, 0);
    chk("R9", "all clear", {pend_ext_o, pend_tod_o, pend_cpt_o}, 0);

    // R4: queued entry before tod
    ext_mask_i = 0; tod_evt_i = 1;
    push_one(16'h0042); tod_evt_i = 0;
    ext_mask_i = 1;
    #1 chk("R4", "queued first", irq_code_o, 16'h0042);
    chk("R4", "tod waits", pend_tod_o, 1);
    ack_one();
    chk("R9", "hard kept for tod", hard_req_o, 1);
    tick();
    chk("R4", "tod after queue", irq_code_o, 16'h1004);
    ack_one();

    // R6/R12: LIFO
    ext_mask_i = 0;
    push_one(16'h000A); push_one(16'h000B); push_one(16'h000C);
    chk("R7", "pend_ext set", pend_ext_o, 1);
    ext_mask_i = 1;
    #1 chk("R6", "top C", irq_code_o, 16'h000C);
    chk("R6", "p32 C", irq_p32_o, 32'hA5A5000C);
    ack_one(); chk("R12", "then B", irq_code_o, 16'h000B);
    ack_one(); chk("R12", "then A", irq_code_o, 16'h000A);
    ack_one(); chk("R7", "empty", pend_ext_o, 0);

    // R10: overflow
    ext_mask_i = 0;
    for (int i = 0; i < DEPTH + 1; i++) push_one(16'h0100 + 16'(i));
    chk("R10", "ovf", ovf_o, 1);
    ext_mask_i = 1;
    #1 chk("R10", "extra dropped", irq_code_o, 16'h0100 + 16'(DEPTH - 1));
    for (int i = DEPTH - 1; i >= 0; i--) begin
      chk("R10", "contents", irq_code_o, 16'h0100 + 16'(i));
      ack_one();
    end
    chk("R10", "drained", pend_ext_o, 0);
    chk("R10", "ovf sticky", ovf_o, 1);

    // R11: fatal ack
    ext_mask_i = 0;
    push_one(16'h0077);
    ack_one();
    chk("R11", "fatal masked ack", fatal_o, 1);
    chk("R11", "no pop", pend_ext_o, 1);
    ext_mask_i = 1;
    #1 chk("R11", "entry kept", irq_code_o, 16'h0077);

    do_reset();
    ext_mask_i = 1;
    ack_one();
    chk("R11", "fatal empty ack", fatal_o, 1);

    // random phase with LIFO model
    do_reset();
    void'($urandom(32'd4242));
    ext_mask_i = 1;
    m_n = 0;
    for (int it = 0; it < 600; it++) begin
      logic do_push, do_ack;
      logic [15:0] c;
      logic [31:0] p;
      do_push = ($urandom % 3) != 0;
      do_ack  = (m_n > 0) && (($urandom % 2) == 0);
      c = 16'($urandom); p = $urandom;
      push_i = do_push; push_code_i = c; push_p32_i = p; push_p64_i = {p, ~p};
      ack_i = do_ack;
      #1;
      chk("R12", "rand valid", irq_valid_o, m_n > 0);
      if (m_n > 0) begin
        chk("R6", "rand code", irq_code_o, m_code[m_n-1]);
        chk("R6", "rand p32", irq_p32_o, m_p32[m_n-1]);
      end
      tick();
      if (do_ack) m_n--;
      if (do_push && m_n < DEPTH) begin
        m_code[m_n] = c; m_p32[m_n] = p; m_n++;
      end
    end
    push_i = 0; ack_i = 0;
    #1 chk("R7", "rand pend_ext", pend_ext_o, m_n > 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule